// File: doc/BRIEF.md
# DRAM Auto Refresh Scheduler

This block decides when a DDR SDRAM controller must spend a command slot on an AUTO REFRESH. A free-running interval counter marks each average refresh period, which is a parameterized number of clock cycles standing for the 7.8125 µs maximum average spacing. Each period adds one to a count of refreshes owed. The command arbiter sees a normal request while anything is owed. It may grant that request at once or defer it while the data bus is busy.

Deferral is bounded. Once eight refreshes are owed the block raises an urgent request, which the arbiter must serve ahead of other traffic. This keeps the gap between two refreshes within nine average periods. If one more period passes without service, the owed count stops at nine and a sticky violation flag is set. Every granted refresh pays back exactly one owed refresh, and a grant leads to one refresh command only.

After a grant the block holds a busy window of tRFC cycles. During that window no command may be granted and it does not request again. A CKE-hold output tells the clock-enable logic to keep CKE high from the grant cycle to the end of the window. The memory generates the refresh row internally, so the block drives no address.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset the owed count rises by one every TICK_CYC cycles. With no grants, `ref_req` first goes high after exactly TICK_CYC rising clock edges with reset low.
- R2: `ref_req` is 1 exactly when at least one refresh is owed and the busy window is not active.
- R3: `ref_urgent` is 1 exactly when at least MAX_DEFER (default 8) refreshes are owed and the busy window is not active. When it is 1, `ref_req` is also 1.
- R4: The owed count saturates at MAX_DEFER+1. The cycle in which it reaches that value sets `defer_viol`, and only reset clears `defer_viol`.
- R5: A grant is accepted only when `ref_grant` and `ref_req` are both 1. Each accepted grant takes exactly one from the owed count. A grant while `ref_req` is 0 has no effect.
- R6: An accepted grant makes `ref_busy` 1 for exactly RFC_CYC cycles, starting the cycle after the grant. Grants during the window are ignored.
- R7: `cke_hold` is 1 in the cycle of an accepted grant and in every busy cycle, and 0 at all other times.
- R8: A synchronous active-high `rst` clears the owed count, the interval counter, the busy window and `defer_viol`.
- R9: When a period ends in the same cycle as an accepted grant, the owed count is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_grant | input | 1 | Arbiter issues the refresh command this cycle |
| ref_req | output | 1 | At least one refresh owed and not busy |
| ref_urgent | output | 1 | Deferral limit reached; refresh must go next |
| ref_busy | output | 1 | tRFC window after an issued refresh |
| cke_hold | output | 1 | CKE must stay high |
| defer_viol | output | 1 | Sticky: deferral limit exceeded |

## Verification
The end of an interval period and an accepted grant can fall in the same clock edge. In that case the owed count must net to zero rather than rising or falling. The bench causes this on purpose: with eight refreshes owed, it watches its own model of the interval counter and grants in the last cycle of the period. It then checks that `ref_urgent` is still high once the busy window has closed. Random grants run against a cycle model computed from the requirements and hit this coincidence many more times, and every such cycle is compared against the model.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    // Request outputs of the credit tracker
    typedef struct packed {
        logic req;
        logic urgent;
        logic viol;
    } ref_flags_t;

    // Direction of the owed-count update in one cycle
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } owed_step_e;

    function automatic owed_step_e pick_step(input logic tick, input logic take);
        if (tick && !take)
            return STEP_UP;
        else if (take && !tick)
            return STEP_DOWN;
        else
            return STEP_HOLD;
    endfunction

endpackage

// File: rtl/ref_interval_ticker.sv
module ref_interval_ticker #(
    parameter int TICK_CYC = 976
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
    localparam logic [W-1:0] LAST = W'(TICK_CYC - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/ref_credit.sv
module ref_credit
    import dram_ref_pkg::*;
#(
    parameter int MAX_DEFER = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       busy,
    input  logic       grant,
    output logic       take,
    output ref_flags_t flags
);
    localparam int SAT = MAX_DEFER + 1;
    localparam int OW  = $clog2(SAT + 1);
    localparam logic [OW-1:0] SAT_V = OW'(SAT);
    localparam logic [OW-1:0] URG_V = OW'(MAX_DEFER);

    logic [OW-1:0] owed, owed_n;
    logic          viol;
    owed_step_e    step;

    assign flags.req    = (owed != '0) && !busy;
    assign flags.urgent = (owed >= URG_V) && !busy;
    assign flags.viol   = viol;
    assign take         = grant && flags.req;
    assign step         = pick_step(tick, take);

    always_comb begin
        owed_n = owed;
        case (step)
            STEP_UP:   if (owed != SAT_V) owed_n = owed + 1'b1;
            STEP_DOWN: owed_n = owed - 1'b1;
            default:   owed_n = owed;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owed <= '0;
            viol <= 1'b0;
        end else begin
            owed <= owed_n;
            if (owed_n == SAT_V)
                viol <= 1'b1;
        end
    end

    // R4
    owed_cap_chk: assert property (@(posedge clk) disable iff (rst)
        owed <= SAT_V);
    // R4
    viol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        viol |=> viol);
    // R3
    urgent_has_req_chk: assert property (@(posedge clk) disable iff (rst)
        flags.urgent |-> flags.req);
    // R9
    net_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && take) |=> owed == $past(owed));
    // R5
    take_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !tick) |=> owed == $past(owed) - 1'b1);

endmodule

// File: rtl/ref_busy_timer.sv
module ref_busy_timer #(
    parameter int RFC_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(RFC_CYC + 1);
    localparam logic [TW-1:0] LOAD = TW'(RFC_CYC);

    logic [TW-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst)
            tmr <= '0;
        else if (start)
            tmr <= LOAD;
        else if (tmr != '0)
            tmr <= tmr - 1'b1;
    end

    assign busy = (tmr != '0);

    // R6
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
    // R6
    busy_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_ref_pkg::*;
#(
    parameter int TICK_CYC  = 976,
    parameter int RFC_CYC   = 16,
    parameter int MAX_DEFER = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_grant,
    output logic ref_req,
    output logic ref_urgent,
    output logic ref_busy,
    output logic cke_hold,
    output logic defer_viol
);
    logic       tick;
    logic       take;
    ref_flags_t flags;

    ref_interval_ticker #(.TICK_CYC(TICK_CYC)) u_ticker (
        .clk(clk), .rst(rst), .tick(tick)
    );

    ref_credit #(.MAX_DEFER(MAX_DEFER)) u_credit (
        .clk(clk), .rst(rst), .tick(tick), .busy(ref_busy),
        .grant(ref_grant), .take(take), .flags(flags)
    );

    ref_busy_timer #(.RFC_CYC(RFC_CYC)) u_timer (
        .clk(clk), .rst(rst), .start(take), .busy(ref_busy)
    );

    assign ref_req    = flags.req;
    assign ref_urgent = flags.urgent;
    assign defer_viol = flags.viol;
    assign cke_hold   = ref_busy || take;

    // R6
    grant_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_grant && ref_req) |=> ref_busy);
    // R7
    cke_cover_chk: assert property (@(posedge clk) disable iff (rst)
        ref_busy |-> cke_hold);
    // R2
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ref_busy |-> !ref_req);

endmodule

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
    localparam int TICK = 40;
    localparam int RFC  = 6;
    localparam int MAXD = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_grant = 1'b0;
    logic ref_req, ref_urgent, ref_busy, cke_hold, defer_viol;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference model state
    int m_cnt = 0, m_owed = 0, m_tmr = 0;
    bit m_viol = 0;

    always #4 clk = ~clk;

    dram_refresh_sched #(.TICK_CYC(TICK), .RFC_CYC(RFC), .MAX_DEFER(MAXD)) u_dram_refresh_sched (
        .clk(clk), .rst(rst), .ref_grant(ref_grant), .ref_req(ref_req),
        .ref_urgent(ref_urgent), .ref_busy(ref_busy), .cke_hold(cke_hold),
        .defer_viol(defer_viol)
    );

    function automatic bit e_req(int o, int t);
        return (o >= 1) && (t == 0);
    endfunction
    function automatic bit e_urg(int o, int t);
        return (o >= MAXD) && (t == 0);
    endfunction
    function automatic bit e_take(bit g, int o, int t);
        return g && e_req(o, t);
    endfunction
    function automatic int e_owed(int o, bit tk, bit take);
        if (tk && !take) return (o == MAXD + 1) ? o : o + 1;
        if (take && !tk) return o - 1;
        return o;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 0; m_owed <= 0; m_tmr <= 0; m_viol <= 0;
        end else begin
            automatic bit tk = (m_cnt == TICK - 1);
            automatic bit tak = e_take(ref_grant, m_owed, m_tmr);
            automatic int no = e_owed(m_owed, tk, tak);
            m_cnt  <= tk ? 0 : m_cnt + 1;
            m_owed <= no;
            m_tmr  <= tak ? RFC : (m_tmr > 0 ? m_tmr - 1 : 0);
            if (no == MAXD + 1) m_viol <= 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // cycle compare, sampled 6 ns after each rising edge
    always @(posedge clk) begin
        #6;
        if (!done) begin
            automatic bit xr = e_req(m_owed, m_tmr);
            automatic bit xu = e_urg(m_owed, m_tmr);
            automatic bit xb = (m_tmr != 0);
            automatic bit xc = xb || e_take(ref_grant, m_owed, m_tmr);
            chk(ref_req == xr, "R2 ref_req", ref_req, xr);
            chk(ref_urgent == xu, "R3 ref_urgent", ref_urgent, xu);
            chk(ref_busy == xb, "R6 ref_busy", ref_busy, xb);
            chk(cke_hold == xc, "R7 cke_hold", cke_hold, xc);
            chk(defer_viol == m_viol, "R4 defer_viol", defer_viol, m_viol);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        cyc(3);
        // R8 reset state
        chk(!ref_req && !ref_busy && !defer_viol && !cke_hold, "R8 reset outputs", ref_req, 0);
        rst = 1'b0;
        // R1: first request exactly TICK edges after reset release
        cyc(TICK - 1);
        chk(ref_req == 0, "R1 before first period", ref_req, 0);
        cyc(1);
        chk(ref_req == 1, "R1 after first period", ref_req, 1);
        // R3: urgent once eight are owed
        while (m_owed < MAXD) cyc(1);
        chk(ref_urgent == 1, "R3 urgent at limit", ref_urgent, 1);
        // R9: grant in the last cycle of a period
        while (m_cnt != TICK - 1) cyc(1);
        ref_grant = 1'b1;
        cyc(1);
        ref_grant = 1'b0;
        cyc(RFC);
        chk(ref_urgent == 1, "R9 grant on tick nets zero", ref_urgent, 1);
        chk(defer_viol == 0, "R9 no violation", defer_viol, 0);
        // R4: miss one more period
        cyc(TICK + 2);
        chk(defer_viol == 1, "R4 violation set", defer_viol, 1);
        cyc(2 * TICK);
        // R6: grant held high through the busy window
        ref_grant = 1'b1;
        cyc(1);
        cyc(RFC - 1);
        chk(ref_busy == 1, "R6 busy last cycle", ref_busy, 1);
        ref_grant = 1'b0;
        cyc(1);
        chk(ref_busy == 0, "R6 busy ends after RFC", ref_busy, 0);
        // R5: drain owed refreshes, then grants without a request do nothing
        for (int k = 0; k < 40 && m_owed > 0; k++) begin
            while (!ref_req && m_owed > 0) cyc(1);
            ref_grant = 1'b1; cyc(1); ref_grant = 1'b0;
        end
        while (m_tmr != 0) cyc(1);
        chk(defer_viol == 1, "R4 violation sticky", defer_viol, 1);
        if (m_cnt < TICK - 3) begin
            ref_grant = 1'b1; cyc(1); ref_grant = 1'b0;
            chk(ref_busy == 0, "R5 grant without request ignored", ref_busy, 0);
        end
        // R8: reset mid-run
        while (m_owed < 3) cyc(1);
        rst = 1'b1; cyc(2);
        chk(!ref_req && !defer_viol && !ref_busy, "R8 reset clears", ref_req, 0);
        rst = 1'b0;
        // random grants
        for (int i = 0; i < 6000; i++) begin
            ref_grant = (($urandom % 32) < ((i / 1000) % 2 == 0 ? 2 : 12));
            cyc(1);
        end
        ref_grant = 1'b0;
        cyc(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        done = 1;
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule